// File: doc/BRIEF.md
# Outstanding Atomic Completion Counter

This block tracks the atomic operations that are in flight for a single cache line, so that the line can leave its atomic phase once every forwarded atomic has come back. The first atomic accepted while the line is Invalid or Valid drops the cached copy and starts tracking. Each further atomic is accepted and forwarded at once, and adds one to the count. Each result that returns from memory is passed on to the requester named in it, and subtracts one from the count.

When a subtraction brings the count to zero, a completion trigger is placed into a one-deep slot and becomes visible one cycle later. The consumer pops the trigger. At that moment the count is checked again. If it is still zero, the tracking entry is released. If an atomic was accepted in the meantime, the trigger is simply dropped and tracking continues. Completion is therefore deferred, and a late atomic cancels the release instead of racing it.

The atomic input and the result path use valid/ready handshakes. The issue side applies back-pressure when the count is at its maximum, when the line is dirty and must be written back first, and in the cycle in which a release is taking effect. The result side is a pass-through whose ready signal follows the downstream ready.

Top module: `atomic_tracker`

## Requirements
- R1: After reset, count_o is 0, busy_o, trig_valid_o and err_o are 0.
- R2: With busy_o low and line_st_i equal to 0 (Invalid) or 1 (Valid), an asserted issue_valid_i is accepted. inval_o pulses in that cycle. From the next cycle busy_o is 1 and count_o is 1.
- R3: With busy_o low and line_st_i equal to 2 (Modified) or 3 (Written), issue_ready_o is 0, wb_req_o follows issue_valid_i, and the count does not change.
- R4: While busy_o is high, an accepted atomic adds one to count_o whatever line_st_i is, and inval_o stays 0.
- R5: relay_valid_o, relay_data_o and relay_dest_o equal rsp_valid_i, rsp_data_i and rsp_dest_i, and rsp_ready_o equals relay_ready_i. A result subtracts one from count_o only when rsp_valid_i and relay_ready_i are both high.
- R6: When a result brings count_o from 1 to 0 with no atomic accepted in the same cycle, trig_valid_o is 1 from the next cycle until it is popped.
- R7: trig_done_o is 1 exactly when trig_valid_o is 1 and count_o is 0. Popping in that state pulses release_o and holds issue_ready_o low in that cycle. From the next cycle busy_o and trig_valid_o are 0.
- R8: Popping while count_o is nonzero gives trig_done_o = 0 and no release. busy_o stays 1 and trig_valid_o clears.
- R9: At count_o = 63 (the maximum for a 6-bit counter) issue_ready_o is 0 and the count does not wrap.
- R10: A result handshake while count_o is 0 sets err_o, which stays 1 until reset. The count stays 0.
- R11: An atomic accepted in the same cycle as a result handshake leaves count_o unchanged and raises no trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_st_i | input | 2 | Line state: 0 Invalid, 1 Valid, 2 Modified, 3 Written |
| issue_valid_i | input | 1 | Atomic request present |
| issue_ready_o | output | 1 | Atomic accepted and forwarded this cycle when high with valid |
| inval_o | output | 1 | Drop the cached copy (first atomic) |
| wb_req_o | output | 1 | Write-back needed before the atomic can enter |
| rsp_valid_i | input | 1 | Atomic result from memory present |
| rsp_ready_o | output | 1 | Result taken |
| rsp_data_i | input | DATA_W | Result data |
| rsp_dest_i | input | REQ_W | Original requester of the result |
| relay_valid_o | output | 1 | Result toward the requester |
| relay_ready_i | input | 1 | Requester side can take the result |
| relay_data_o | output | DATA_W | Relayed data |
| relay_dest_o | output | REQ_W | Relayed requester |
| trig_valid_o | output | 1 | Completion trigger pending |
| trig_pop_i | input | 1 | Consume the trigger |
| trig_done_o | output | 1 | Pending trigger would complete tracking |
| release_o | output | 1 | Tracking entry freed, line returns to Invalid |
| busy_o | output | 1 | Line is in its atomic phase |
| count_o | output | CNT_W | Atomics in flight |
| err_o | output | 1 | Sticky flag for a result arriving at count zero |

## Verification
The assertions assume that line_st_i is one of the four encoded states and that trig_pop_i is only a request, which is ignored when no trigger is pending. They do not assume that results are well behaved, because the underflow case is itself a requirement. The stimulus holds every input steady across a clock edge and changes it two time units after the edge. It raises the pop only in cycles where a trigger is visible, except in the one check that shows an empty pop has no effect. It does not deliberately pair a pop with an issue on a zero count except to observe the back-pressure.

// File: rtl/aoc_pkg.sv
package aoc_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_VAL = 2'd1,
    LS_MOD = 2'd2,
    LS_WRT = 2'd3
  } line_st_e;
endpackage

// File: rtl/aoc_counter.sv
module aoc_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max,
  output logic             is_zero,
  output logic             hits_zero,
  output logic             underflow
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_max    = (cnt == MAX);
  assign is_zero   = (cnt == '0);
  assign hits_zero = dec && !inc && (cnt == ONE);
  assign underflow = dec && !inc && is_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (inc && !dec && !at_max) begin
      cnt <= cnt + ONE;
    end else if (dec && !inc && !is_zero) begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/aoc_trig_slot.sv
module aoc_trig_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic pop,
  output logic valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (set) begin
      valid <= 1'b1;
    end else if (pop) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/atomic_tracker.sv
module atomic_tracker
  import aoc_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 32,
  parameter int REQ_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        line_st_i,
  input  logic              issue_valid_i,
  output logic              issue_ready_o,
  output logic              inval_o,
  output logic              wb_req_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  input  logic [REQ_W-1:0]  rsp_dest_i,
  output logic              relay_valid_o,
  input  logic              relay_ready_i,
  output logic [DATA_W-1:0] relay_data_o,
  output logic [REQ_W-1:0]  relay_dest_o,
  output logic              trig_valid_o,
  input  logic              trig_pop_i,
  output logic              trig_done_o,
  output logic              release_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              err_o
);
  line_st_e st;
  logic dirty_line, closing, issue_fire, rsp_fire;
  logic at_max, is_zero, hits_zero, underflow;

  assign st         = line_st_e'(line_st_i);
  assign dirty_line = (st == LS_MOD) || (st == LS_WRT);

  // pass-through result path
  assign relay_valid_o = rsp_valid_i;
  assign relay_data_o  = rsp_data_i;
  assign relay_dest_o  = rsp_dest_i;
  assign rsp_ready_o   = relay_ready_i;
  assign rsp_fire      = rsp_valid_i && relay_ready_i;

  // deferred completion check
  assign trig_done_o = trig_valid_o && is_zero;
  assign release_o   = trig_pop_i && trig_done_o;
  assign closing     = release_o;

  assign issue_ready_o = !at_max && !closing && (busy_o || !dirty_line);
  assign issue_fire    = issue_valid_i && issue_ready_o;
  assign inval_o       = issue_fire && !busy_o;
  assign wb_req_o      = issue_valid_i && !busy_o && dirty_line;

  aoc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (issue_fire),
    .dec       (rsp_fire),
    .cnt       (count_o),
    .at_max    (at_max),
    .is_zero   (is_zero),
    .hits_zero (hits_zero),
    .underflow (underflow)
  );

  aoc_trig_slot u_trig (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (hits_zero),
    .pop   (trig_pop_i),
    .valid (trig_valid_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      if (release_o) busy_o <= 1'b0;
      else if (issue_fire) busy_o <= 1'b1;
      if (underflow) err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/atomic_tracker_chk.sv
module atomic_tracker_chk #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       line_st_i,
  input logic             issue_valid_i,
  input logic             issue_ready_o,
  input logic             rsp_valid_i,
  input logic             relay_ready_i,
  input logic             trig_valid_o,
  input logic             trig_pop_i,
  input logic             release_o,
  input logic             busy_o,
  input logic [CNT_W-1:0] count_o,
  input logic             err_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};
  logic fire_i, fire_r;
  assign fire_i = issue_valid_i && issue_ready_o;
  assign fire_r = rsp_valid_i && relay_ready_i;

  assert_wb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && line_st_i[1]) |-> !issue_ready_o);
  assert_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && fire_i) |=> (busy_o && count_o == 1));
  assert_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && fire_i && !fire_r) |=> (count_o == $past(count_o) + 1'b1));
  assert_trig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_r && !fire_i && count_o == 1) |=> trig_valid_o);
  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> (!busy_o && !trig_valid_o));
  assert_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pop_i && trig_valid_o && count_o != 0) |=> busy_o);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == MAX) |-> !issue_ready_o);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && fire_r) |=> $stable(count_o));
endmodule

bind atomic_tracker atomic_tracker_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_atomic_tracker.sv
module sim_atomic_tracker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [1:0] line_st_i = 2'd0;
  logic issue_valid_i = 0, rsp_valid_i = 0, relay_ready_i = 0, trig_pop_i = 0;
  logic [31:0] rsp_data_i = '0;
  logic [3:0]  rsp_dest_i = '0;
  logic issue_ready_o, inval_o, wb_req_o, rsp_ready_o, relay_valid_o;
  logic [31:0] relay_data_o;
  logic [3:0] relay_dest_o;
  logic trig_valid_o, trig_done_o, release_o, busy_o, err_o;
  logic [5:0] count_o;

  atomic_tracker u0 (.*);

  int checks = 0, fails = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0] st; logic iss; logic rsp; logic rdy; logic pop;
    logic [5:0] cnt; logic trg; logic bsy;
  } vec_t;

  localparam vec_t VECS [13] = '{
    '{2'd0,1'b1,1'b0,1'b1,1'b0,6'd1,1'b0,1'b1}, // R2 first atomic
    '{2'd2,1'b1,1'b0,1'b1,1'b0,6'd2,1'b0,1'b1}, // R4 further atomic
    '{2'd0,1'b0,1'b1,1'b1,1'b0,6'd1,1'b0,1'b1}, // R5 decrement
    '{2'd0,1'b0,1'b1,1'b1,1'b0,6'd0,1'b1,1'b1}, // R6 trigger
    '{2'd0,1'b1,1'b0,1'b1,1'b0,6'd1,1'b1,1'b1}, // R4 late atomic
    '{2'd0,1'b0,1'b0,1'b1,1'b1,6'd1,1'b0,1'b1}, // R8 not done
    '{2'd0,1'b0,1'b1,1'b1,1'b0,6'd0,1'b1,1'b1}, // R6
    '{2'd0,1'b0,1'b0,1'b1,1'b1,6'd0,1'b0,1'b0}, // R7 release
    '{2'd1,1'b1,1'b0,1'b1,1'b0,6'd1,1'b0,1'b1}, // R2 from Valid
    '{2'd1,1'b1,1'b1,1'b1,1'b0,6'd1,1'b0,1'b1}, // R11 both
    '{2'd1,1'b0,1'b1,1'b0,1'b0,6'd1,1'b0,1'b1}, // R5 no handshake
    '{2'd1,1'b0,1'b1,1'b1,1'b0,6'd0,1'b1,1'b1}, // R6
    '{2'd1,1'b0,1'b0,1'b1,1'b1,6'd0,1'b0,1'b0}  // R7
  };

  task automatic idle();
    issue_valid_i = 0; rsp_valid_i = 0; trig_pop_i = 0; relay_ready_i = 1;
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    check("R1 count", count_o, 0);
    check("R1 busy", busy_o, 0);
    check("R1 trig", trig_valid_o, 0);
    check("R1 err", err_o, 0);

    foreach (VECS[i]) begin
      @(negedge clk);
      line_st_i = VECS[i].st; issue_valid_i = VECS[i].iss;
      rsp_valid_i = VECS[i].rsp; relay_ready_i = VECS[i].rdy;
      trig_pop_i = VECS[i].pop;
      #1;
      if (VECS[i].pop) check("R7 R8 done flag", trig_done_o, VECS[i].cnt == 0);
      if (VECS[i].iss && i == 0) check("R2 inval pulse", inval_o, 1);
      if (VECS[i].iss && i == 1) check("R4 no inval", inval_o, 0);
      @(posedge clk); #2;
      check($sformatf("R2-R11 vec%0d count", i), count_o, VECS[i].cnt);
      check($sformatf("vec%0d trig R6", i), trig_valid_o, VECS[i].trg);
      check($sformatf("vec%0d busy R7", i), busy_o, VECS[i].bsy);
      idle();
    end

    // R3 dirty line blocks the first atomic
    @(negedge clk);
    line_st_i = 2'd2; issue_valid_i = 1; #1;
    check("R3 ready", issue_ready_o, 0);
    check("R3 wb_req", wb_req_o, 1);
    @(posedge clk); #2;
    line_st_i = 2'd3; #1;
    check("R3 wb_req W", wb_req_o, 1);
    @(posedge clk); #2;
    check("R3 count", count_o, 0);
    check("R3 busy", busy_o, 0);
    idle();

    // R5 relay pass-through
    @(negedge clk);
    line_st_i = 2'd0; issue_valid_i = 1;
    @(posedge clk); #2 idle();
    @(negedge clk);
    rsp_valid_i = 1; rsp_data_i = 32'hCAFE_1234; rsp_dest_i = 4'd9; relay_ready_i = 0; #1;
    check("R5 relay valid", relay_valid_o, 1);
    check("R5 relay data", relay_data_o, 32'hCAFE_1234);
    check("R5 relay dest", relay_dest_o, 9);
    check("R5 rsp ready", rsp_ready_o, 0);
    @(posedge clk); #2;
    check("R5 count held", count_o, 1);
    relay_ready_i = 1;
    @(posedge clk); #2 idle();
    check("R6 trigger", trig_valid_o, 1);
    // R7 back-pressure during release
    @(negedge clk);
    trig_pop_i = 1; issue_valid_i = 1; #1;
    check("R7 release", release_o, 1);
    check("R7 ready low", issue_ready_o, 0);
    @(posedge clk); #2 idle();
    check("R7 busy cleared", busy_o, 0);
    check("R7 count", count_o, 0);

    // R9 saturation
    @(negedge clk);
    line_st_i = 2'd0; issue_valid_i = 1;
    repeat (64) @(posedge clk);
    #2;
    check("R9 count max", count_o, 63);
    check("R9 ready", issue_ready_o, 0);
    idle();
    @(negedge clk); rsp_valid_i = 1;
    repeat (63) @(posedge clk);
    #2 idle();
    check("R9 drained", count_o, 0);
    check("R6 trigger after drain", trig_valid_o, 1);
    @(negedge clk); trig_pop_i = 1;
    @(posedge clk); #2 idle();
    check("R7 busy", busy_o, 0);

    // R8 empty pop has no effect
    @(negedge clk); trig_pop_i = 1;
    @(posedge clk); #2 idle();
    check("R8 empty pop release", release_o, 0);
    check("R8 empty pop trig", trig_valid_o, 0);

    // R10 underflow
    check("R10 err before", err_o, 0);
    @(negedge clk); rsp_valid_i = 1;
    @(posedge clk); #2 idle();
    check("R10 err", err_o, 1);
    check("R10 count", count_o, 0);
    repeat (3) @(posedge clk);
    #2 check("R10 sticky", err_o, 1);
    rst_n = 0;
    @(posedge clk); #2 rst_n = 1;
    check("R1 err after reset", err_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule